// File: doc/BRIEF.md
# Packed Lane SIMD Execution Unit

This block is a one-stage execution unit for packed integer arithmetic. Each 32-bit operand is read either as four 8-bit lanes or as two 16-bit lanes, with lane 0 in the least significant bits. One opcode selects one of several operations:

- lane-wise add and subtract,
- lane-wise shifts, where each lane of the first operand moves by the count in the matching lane of the second,
- lane-wise equality and less-than compares that return lane masks,
- a widening dot product that may add into a 32-bit running value,
- a one-source or two-source lane shuffle steered by a mask vector.

The result is captured in a single output register. It therefore appears on the clock edge after the operands are presented.

A sign select input controls how lanes are extended. It chooses sign or zero extension before multiplication and before ordered comparison, and it chooses between arithmetic and logical right shift. Lane arithmetic wraps inside each lane and never carries across a lane boundary. The dot product extends every lane to the full 32 bits before multiplying and sums the products modulo 2^32.

Top module: `simd_dot_unit`

## Requirements
- R1: While reset is asserted `res_o` is zero. In operation `res_o` holds the result for the inputs sampled at the previous rising clock edge.
- R2: `half_i`=0 selects four 8-bit lanes and `half_i`=1 selects two 16-bit lanes. Lane k occupies bits [k*W+W-1 : k*W]. Opcode 0 adds lanes and opcode 1 subtracts b from a. Both wrap modulo 2^W with no carry between lanes.
- R3: Opcode 2 shifts each a lane left, and opcode 3 shifts it right. The count is the matching b lane modulo W. The right shift is arithmetic when `sgn_i`=1 and logical when `sgn_i`=0.
- R4: Opcode 4 (equal) and opcode 5 (a less than b) set a lane to all ones when true and to zero when false. Opcode 5 compares signed when `sgn_i`=1 and unsigned when `sgn_i`=0.
- R5: Opcode 6 returns the sum over all lanes of a_k*b_k. Each lane is sign-extended (`sgn_i`=1) or zero-extended (`sgn_i`=0) to 32 bits, and the sum wraps modulo 2^32.
- R6: Opcode 7 returns `src_c_i` plus the same sum as R5, modulo 2^32.
- R7: Opcode 8 sets output lane k to a lane (b lane k modulo N), where N is the lane count.
- R8: Opcode 9 numbers a's lanes 0..N-1 and b's lanes N..2N-1. It sets output lane k to the lane chosen by c lane k modulo 2N.
- R9: Opcodes 10 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| half_i | input | 1 | Lane size: 0 = bytes, 1 = halfwords |
| sgn_i | input | 1 | Signed lane interpretation |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand, or mask for the one-source shuffle |
| src_c_i | input | 32 | Accumulator, or mask for the two-source shuffle |
| res_o | output | 32 | Registered result |

## Verification
The bench builds the unit with its default 32-bit width. That width gives four byte lanes and two halfword lanes, so a shuffle mask wraps modulo 8 or 4 and a shift count modulo 8 or 16. The bench sweeps every one of the sixteen opcode codes against both lane sizes and both signedness settings, using 256 operand patterns each. These patterns cover every mask index before and after the wrap, every shift count, lanes on both sides of the sign boundary, and equal and unequal lane pairs. Expected results come from lane arithmetic done in wide integers in the bench.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_SLL    = 4'd2,
        OP_SRL    = 4'd3,
        OP_CEQ    = 4'd4,
        OP_CLT    = 4'd5,
        OP_DOT    = 4'd6,
        OP_DOTACC = 4'd7,
        OP_SHUF1  = 4'd8,
        OP_SHUF2  = 4'd9
    } simd_op_e;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int NL = DATA_W / LANE_W;
    localparam logic [LANE_W-1:0] SHMOD = LANE_W'(LANE_W);

    simd_op_e op_e;
    assign op_e = simd_op_e'(op_i);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LANE_W-1:0]        la, lb, amt, r;
        logic signed [LANE_W-1:0] sra;
        logic                     lt;

        assign la  = a_i[i*LANE_W +: LANE_W];
        assign lb  = b_i[i*LANE_W +: LANE_W];
        assign amt = lb % SHMOD;
        assign sra = $signed(la) >>> amt;
        assign lt  = sgn_i ? ($signed(la) < $signed(lb)) : (la < lb);

        always_comb begin
            unique case (op_e)
                OP_ADD:  r = la + lb;
                OP_SUB:  r = la - lb;
                OP_SLL:  r = la << amt;
                OP_SRL:  r = sgn_i ? LANE_W'(sra) : (la >> amt);
                OP_CEQ:  r = {LANE_W{la == lb}};
                OP_CLT:  r = {LANE_W{lt}};
                default: r = '0;
            endcase
        end

        assign res_o[i*LANE_W +: LANE_W] = r;
    end
endmodule

// File: rtl/simd_dot.sv
module simd_dot #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              sgn_i,
    input  logic              acc_en_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] c_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int NL = DATA_W / LANE_W;
    localparam int XW = DATA_W - LANE_W;

    logic [DATA_W-1:0] prod [NL];

    for (genvar i = 0; i < NL; i++) begin : g_mul
        logic [LANE_W-1:0] la, lb;
        logic [DATA_W-1:0] ea, eb;

        assign la = a_i[i*LANE_W +: LANE_W];
        assign lb = b_i[i*LANE_W +: LANE_W];
        assign ea = {{XW{sgn_i & la[LANE_W-1]}}, la};
        assign eb = {{XW{sgn_i & lb[LANE_W-1]}}, lb};
        assign prod[i] = ea * eb;
    end

    always_comb begin
        res_o = acc_en_i ? c_i : '0;
        for (int k = 0; k < NL; k++) begin
            res_o = res_o + prod[k];
        end
    end
endmodule

// File: rtl/simd_shuffle.sv
module simd_shuffle #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              two_src_i,
    input  logic [DATA_W-1:0] v0_i,
    input  logic [DATA_W-1:0] v1_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int NL = DATA_W / LANE_W;
    localparam logic [LANE_W-1:0] MOD1 = LANE_W'(NL);
    localparam logic [LANE_W-1:0] MOD2 = LANE_W'(2 * NL);

    logic [2*DATA_W-1:0] pool;
    assign pool = {v1_i, v0_i};

    for (genvar i = 0; i < NL; i++) begin : g_pick
        logic [LANE_W-1:0] ml, sel;

        assign ml  = mask_i[i*LANE_W +: LANE_W];
        assign sel = two_src_i ? (ml % MOD2) : (ml % MOD1);
        assign res_o[i*LANE_W +: LANE_W] = pool[int'(sel)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/simd_dot_unit.sv
module simd_dot_unit
    import simd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              half_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [DATA_W-1:0] src_c_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    simd_op_e          op_e;
    logic [DATA_W-1:0] alu_b, alu_h, dot_b, dot_h, shf_b, shf_h;
    logic [DATA_W-1:0] shf_mask, res_nxt;
    logic              two_src, acc_en;

    assign op_e     = simd_op_e'(op_i);
    assign two_src  = (op_e == OP_SHUF2);
    assign acc_en   = (op_e == OP_DOTACC);
    assign shf_mask = two_src ? src_c_i : src_b_i;

    simd_lane_alu #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_alu_b (
        .op_i(op_i), .sgn_i(sgn_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(alu_b));
    simd_lane_alu #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_alu_h (
        .op_i(op_i), .sgn_i(sgn_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(alu_h));

    simd_dot #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_dot_b (
        .sgn_i(sgn_i), .acc_en_i(acc_en), .a_i(src_a_i), .b_i(src_b_i),
        .c_i(src_c_i), .res_o(dot_b));
    simd_dot #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_dot_h (
        .sgn_i(sgn_i), .acc_en_i(acc_en), .a_i(src_a_i), .b_i(src_b_i),
        .c_i(src_c_i), .res_o(dot_h));

    simd_shuffle #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_shf_b (
        .two_src_i(two_src), .v0_i(src_a_i), .v1_i(src_b_i),
        .mask_i(shf_mask), .res_o(shf_b));
    simd_shuffle #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_shf_h (
        .two_src_i(two_src), .v0_i(src_a_i), .v1_i(src_b_i),
        .mask_i(shf_mask), .res_o(shf_h));

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_CEQ, OP_CLT:
                res_nxt = half_i ? alu_h : alu_b;
            OP_DOT, OP_DOTACC:
                res_nxt = half_i ? dot_h : dot_b;
            OP_SHUF1, OP_SHUF2:
                res_nxt = half_i ? shf_h : shf_b;
            default:
                res_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_o <= '0;
        else        res_o <= res_nxt;
    end
endmodule

// File: rtl/simd_dot_unit_chk.sv
module simd_dot_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_i,
    input logic        half_i,
    input logic        sgn_i,
    input logic [31:0] src_a_i,
    input logic [31:0] src_b_i,
    input logic [31:0] src_c_i,
    input logic [31:0] res_o
);
    function automatic logic lane_masks(logic [31:0] v, logic h);
        if (h) return (v[15:0] == 16'h0 || v[15:0] == 16'hFFFF) &&
                      (v[31:16] == 16'h0 || v[31:16] == 16'hFFFF);
        for (int k = 0; k < 4; k++)
            if (v[k*8 +: 8] != 8'h00 && v[k*8 +: 8] != 8'hFF) return 1'b0;
        return 1'b1;
    endfunction

    AST_CMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 4'd4 || $past(op_i) == 4'd5))
        |-> lane_masks(res_o, $past(half_i))); // R4

    AST_ADD_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd0 && !$past(half_i))
        |-> res_o[7:0] == 8'($past(src_a_i[7:0]) + $past(src_b_i[7:0]))); // R2

    AST_SUB_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd1 && $past(src_a_i) == $past(src_b_i))
        |-> res_o == 32'h0); // R2

    AST_DOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd6 && $past(src_a_i) == 32'h0)
        |-> res_o == 32'h0); // R5

    AST_SHUF_PICK0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd9 && !$past(half_i) &&
         $past(src_c_i[2:0]) == 3'd0)
        |-> res_o[7:0] == $past(src_a_i[7:0])); // R8

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= 4'd10)
        |-> res_o == 32'h0); // R9

    AST_SIGNED_SRL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd3 && $past(sgn_i) && !$past(half_i) &&
         $past(src_a_i[31]))
        |-> res_o[31]); // R3
endmodule

bind simd_dot_unit simd_dot_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .half_i(half_i), .sgn_i(sgn_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i), .res_o(res_o));

// File: tb/simd_dot_unit_tb.sv
`timescale 1ns/1ps
module simd_dot_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op;
    logic        half, sgn;
    logic [31:0] a, b, c;
    logic [31:0] res;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    simd_dot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .half_i(half), .sgn_i(sgn),
        .src_a_i(a), .src_b_i(b), .src_c_i(c), .res_o(res));

    function automatic string req_of(int o);
        case (o)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4, 5:    return "R4";
            6:       return "R5";
            7:       return "R6";
            8:       return "R7";
            9:       return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] model(int o, bit h, bit s,
                                          logic [31:0] x, logic [31:0] y, logic [31:0] z);
        int     nl, lw, idx;
        longint msk, la, lb, lc, sla, slb, v, acc;
        logic [31:0] r;
        nl  = h ? 2 : 4;
        lw  = h ? 16 : 8;
        msk = (longint'(1) << lw) - 1;
        r   = 32'h0;
        acc = (o == 7) ? longint'(z) : 0;
        for (int i = 0; i < nl; i++) begin
            la  = longint'(x >> (i*lw)) & msk;
            lb  = longint'(y >> (i*lw)) & msk;
            lc  = longint'(z >> (i*lw)) & msk;
            sla = (la >= (longint'(1) << (lw-1))) ? la - (longint'(1) << lw) : la;
            slb = (lb >= (longint'(1) << (lw-1))) ? lb - (longint'(1) << lw) : lb;
            v   = 0;
            case (o)
                0: v = la + lb;
                1: v = la - lb;
                2: v = la << (lb % lw);
                3: v = s ? (sla >>> (lb % lw)) : (la >> (lb % lw));
                4: v = (la == lb) ? -1 : 0;
                5: v = (s ? (sla < slb) : (la < lb)) ? -1 : 0;
                6, 7: acc = acc + (s ? sla * slb : la * lb);
                8: begin
                    idx = int'(lb % nl);
                    v = longint'(x >> (idx*lw)) & msk;
                end
                9: begin
                    idx = int'(lc % (2*nl));
                    v = (idx < nl) ? (longint'(x >> (idx*lw)) & msk)
                                   : (longint'(y >> ((idx-nl)*lw)) & msk);
                end
                default: v = 0;
            endcase
            r = r | (32'(v & msk) << (i*lw));
        end
        if (o == 6 || o == 7) r = acc[31:0];
        return r;
    endfunction

    task automatic check(string rq, logic [31:0] exp);
        n_chk++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d half=%0d sgn=%0d a=%h b=%h c=%h actual=%h expected=%h",
                     rq, op, half, sgn, a, b, c, res, exp);
        end
    endtask

    initial begin
        op = 4'd0; half = 1'b0; sgn = 1'b0;
        a = 32'hFFFF_FFFF; b = 32'h0101_0101; c = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R1", 32'h0);   // R1: result held at zero while in reset
        rst_n = 1'b1;
        for (int o = 0; o < 16; o++) begin
            for (int h = 0; h < 2; h++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int i = 0; i < 256; i++) begin
                        @(negedge clk);
                        op = 4'(o); half = h[0]; sgn = s[0];
                        for (int k = 0; k < 4; k++) begin
                            a[k*8 +: 8] = 8'((i * (2*k+1)) + k*37);
                            b[k*8 +: 8] = 8'((i * 7 + k*91) ^ 8'h3C);
                            c[k*8 +: 8] = 8'(i + k*3);
                        end
                        if (i == 1) b = a;        // equal lanes for R4, self-subtract for R2
                        if (i == 2) a = 32'h8000_8080;  // sign boundaries for R3 and R5
                        @(negedge clk);           // one register: result visible here (R1)
                        check(req_of(o), model(o, h[0], s[0], a, b, c));
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule